// File: doc/BRIEF.md
# Mailbox Host Register Interface

This block is a word-addressed memory-mapped slave that sits between a host bus and a downstream command processor. The host builds a command packet by writing words into a command queue. The address it writes to decides where the packet ends: the final word goes to a separate "last word" address. The queue presents the packet to the processor as a valid/ready word stream that carries start and end markers.

The processor returns response packets on a second valid/ready stream, again with start and end markers, into a response queue. The host drains that queue one word per read. Before reading, it can look at a status word that packs the fill level together with the framing flags of the word at the head of the queue.

Two interrupt sources follow queue state directly: "response word waiting" and "command queue has room". Each is masked by its own enable bit, and the result drives a single interrupt line. The command free-space value is published through a short pipeline, so it trails the queue by a fixed number of cycles. Timers and header checking live in neighbouring blocks, so their offsets read as zero here.

Top module: `mbox_host_regs`

## Requirements
- R1: Every read strobe is answered by `avm_rvalid` high exactly one cycle later, with the data on `avm_rdata` in that same cycle. `avm_rvalid` is low in any cycle that does not follow a read strobe.
- R2: Writes to offset 0 queue the non-final words of a command, and a write to offset 1 queues its final word. On the command stream, the first word of each packet has `cmd_sop`=1 and the word written at offset 1 has `cmd_eop`=1. A packet made only of an offset-1 write carries both flags. Words leave in write order.
- R3: A write to offset 0 or 1 while the command queue holds CMD_DEPTH words is dropped, and the queue contents do not change.
- R4: A read of offset 2 returns CMD_DEPTH minus the command queue occupancy with a lag of FS_LAG (3) cycles. A read strobe issued 2 cycles after a write strobe still shows the old value, and one issued 3 cycles after shows the new value.
- R5: `rsp_ready` is high exactly while the response queue holds fewer than RSP_DEPTH words. Reads of offset 5 return the accepted response words in arrival order, one per read.
- R6: A read of offset 6 returns the response fill level in bits 31:2, the head word's end flag in bit 1 and its start flag in bit 0, or 0 when the queue is empty. For example, 11 words with the head marked start read 0x2D, and a lone start+end word reads 0x07.
- R7: A read of offset 5 with an empty response queue returns 0 and removes nothing.
- R8: Offset 8 reads bit 0 = response queue non-empty and bit 1 = command queue not full, with all other bits 0. Both bits clear by themselves when the queue state changes.
- R9: Offset 7 holds enable bits 0, 1, 3, 4 and 5, which are writable and read back. All other bits read 0.
- R10: `irq` is high exactly when some status bit at offset 8 and its matching enable bit at offset 7 are both 1.
- R11: Offsets 3, 4, 9, 10 and 11–15 read 0, and writes to them change nothing readable.
- R12: After reset both queues are empty, the enables are 0, offset 2 reads CMD_DEPTH, `cmd_valid` and `irq` are low and `rsp_ready` is high. Reset is held for at least 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| avm_addr | input | 4 | Word offset |
| avm_wr | input | 1 | Write strobe |
| avm_rd | input | 1 | Read strobe |
| avm_wdata | input | 32 | Write data |
| avm_rdata | output | 32 | Read data, valid with avm_rvalid |
| avm_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| irq | output | 1 | Masked interrupt |
| cmd_valid | output | 1 | Command word available |
| cmd_ready | input | 1 | Processor takes the command word |
| cmd_data | output | 32 | Command word |
| cmd_sop | output | 1 | First word of a command packet |
| cmd_eop | output | 1 | Last word of a command packet |
| rsp_valid | input | 1 | Response word offered |
| rsp_ready | output | 1 | Response queue has room |
| rsp_data | input | 32 | Response word |
| rsp_sop | input | 1 | First word of a response packet |
| rsp_eop | input | 1 | Last word of a response packet |

## Verification
Several behaviours are checked on every cycle by the embedded assertions: the one-cycle read latency, the bound on command queue occupancy, dropped writes while the queue is full, the zero returned for an empty response pop with no pop taking place, and `irq` never rising without an enable set. Other behaviours can only be shown by the bench's scenarios, because they need a known history. These are the framing flags across whole packets, word ordering through both queues, the exact cycle at which the free-space value changes, the packed fill/flag status word, and the masking of each interrupt source.

// File: rtl/mbox_host_regs.sv
module mbox_host_regs #(
  parameter int CMD_DEPTH = 8,
  parameter int RSP_DEPTH = 16,
  parameter int FS_LAG    = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  avm_addr,
  input  logic        avm_wr,
  input  logic        avm_rd,
  input  logic [31:0] avm_wdata,
  output logic [31:0] avm_rdata,
  output logic        avm_rvalid,
  output logic        irq,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [31:0] cmd_data,
  output logic        cmd_sop,
  output logic        cmd_eop,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [31:0] rsp_data,
  input  logic        rsp_sop,
  input  logic        rsp_eop
);
  localparam int CAW = $clog2(CMD_DEPTH);
  localparam int CCW = $clog2(CMD_DEPTH + 1);
  localparam int RAW = $clog2(RSP_DEPTH);
  localparam int RCW = $clog2(RSP_DEPTH + 1);
  localparam int FSN = FS_LAG - 1;
  localparam logic [5:0] IER_MASK = 6'b111011;

  logic [33:0]    cmem [CMD_DEPTH];
  logic [CAW-1:0] cwp, crp;
  logic [CCW-1:0] ccnt;
  logic           mid_pkt;
  logic [33:0]    rmem [RSP_DEPTH];
  logic [RAW-1:0] rwp, rrp;
  logic [RCW-1:0] rcnt;
  logic [CCW-1:0] fs_q [FSN];
  logic [5:0]     ier;
  logic [5:0]     isr;

  wire cwr   = avm_wr && (avm_addr == 4'd0 || avm_addr == 4'd1);
  wire cfull = (ccnt == CCW'(CMD_DEPTH));
  wire cpush = cwr && !cfull;
  wire cpop  = cmd_valid && cmd_ready;
  wire rpush = rsp_valid && rsp_ready;
  wire rpop  = avm_rd && avm_addr == 4'd5 && rcnt != '0;

  assign cmd_valid = (ccnt != '0);
  assign {cmd_sop, cmd_eop, cmd_data} = cmem[crp];
  assign rsp_ready = (rcnt != RCW'(RSP_DEPTH));
  assign isr = {4'b0000, !cfull, rcnt != '0};
  assign irq = |(isr & ier);

  always_ff @(posedge clk)
    if (cpush) cmem[cwp] <= {!mid_pkt, avm_addr == 4'd1, avm_wdata};

  always_ff @(posedge clk)
    if (rpush) rmem[rwp] <= {rsp_sop, rsp_eop, rsp_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp <= '0; crp <= '0; ccnt <= '0; mid_pkt <= 1'b0;
    end else begin
      if (cpush) begin
        cwp     <= (cwp == CAW'(CMD_DEPTH - 1)) ? '0 : cwp + 1'b1;
        mid_pkt <= (avm_addr == 4'd0);
      end
      if (cpop) crp <= (crp == CAW'(CMD_DEPTH - 1)) ? '0 : crp + 1'b1;
      if (cpush && !cpop) ccnt <= ccnt + 1'b1;
      else if (cpop && !cpush) ccnt <= ccnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else begin
      if (rpush) rwp <= (rwp == RAW'(RSP_DEPTH - 1)) ? '0 : rwp + 1'b1;
      if (rpop)  rrp <= (rrp == RAW'(RSP_DEPTH - 1)) ? '0 : rrp + 1'b1;
      if (rpush && !rpop) rcnt <= rcnt + 1'b1;
      else if (rpop && !rpush) rcnt <= rcnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < FSN; i++) fs_q[i] <= CCW'(CMD_DEPTH);
    end else begin
      fs_q[0] <= CCW'(CMD_DEPTH) - ccnt;
      for (int i = 1; i < FSN; i++) fs_q[i] <= fs_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ier <= '0;
    else if (avm_wr && avm_addr == 4'd7) ier <= avm_wdata[5:0] & IER_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      avm_rvalid <= 1'b0;
      avm_rdata  <= '0;
    end else begin
      avm_rvalid <= avm_rd;
      if (avm_rd) begin
        case (avm_addr)
          4'd2: avm_rdata <= 32'(fs_q[FSN-1]);
          4'd5: avm_rdata <= (rcnt != '0) ? rmem[rrp][31:0] : 32'd0;
          4'd6: avm_rdata <= (rcnt != '0) ?
                             ((32'(rcnt) << 2) | {30'd0, rmem[rrp][32], rmem[rrp][33]}) : 32'd0;
          4'd7: avm_rdata <= 32'(ier);
          4'd8: avm_rdata <= 32'(isr);
          default: avm_rdata <= 32'd0;
        endcase
      end
    end
  end

  // R1
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    avm_rd |=> avm_rvalid);
  // R1
  no_spurious_rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    !avm_rd |=> !avm_rvalid);
  // R3
  cmd_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ccnt <= CCW'(CMD_DEPTH));
  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cwr && cfull && !cmd_ready) |=> (ccnt == CCW'(CMD_DEPTH)));
  // R7
  empty_pop_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (avm_rd && avm_addr == 4'd5 && rcnt == '0) |=> avm_rdata == 32'd0);
  // R7
  empty_pop_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (avm_rd && avm_addr == 4'd5 && rcnt == '0 && !rsp_valid) |=> rcnt == '0);
  // R10
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ier != '0);
endmodule

// File: tb/mbox_host_regs_bench.sv
module mbox_host_regs_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] avm_addr = '0;
  logic avm_wr = 1'b0, avm_rd = 1'b0;
  logic [31:0] avm_wdata = '0;
  logic [31:0] avm_rdata;
  logic avm_rvalid, irq;
  logic cmd_valid, cmd_sop, cmd_eop;
  logic cmd_ready = 1'b0;
  logic [31:0] cmd_data;
  logic rsp_valid = 1'b0, rsp_sop = 1'b0, rsp_eop = 1'b0;
  logic rsp_ready;
  logic [31:0] rsp_data = '0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mbox_host_regs u_mbox_host_regs (
    .clk(clk), .rst(rst), .avm_addr(avm_addr), .avm_wr(avm_wr), .avm_rd(avm_rd),
    .avm_wdata(avm_wdata), .avm_rdata(avm_rdata), .avm_rvalid(avm_rvalid), .irq(irq),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_sop(cmd_sop), .cmd_eop(cmd_eop), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_sop(rsp_sop), .rsp_eop(rsp_eop));

  logic [33:0] cap [64];
  int cap_n = 0;
  always @(posedge clk)
    if (cmd_valid && cmd_ready && cap_n < 64) begin
      cap[cap_n] <= {cmd_sop, cmd_eop, cmd_data};
      cap_n <= cap_n + 1;
    end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); avm_wr = 1'b1; avm_addr = a; avm_wdata = d;
    @(negedge clk); avm_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); avm_rd = 1'b1; avm_addr = a;
    @(negedge clk); avm_rd = 1'b0;
    check("R1 rvalid", {31'd0, avm_rvalid}, 32'd1);
    d = avm_rdata;
  endtask

  task automatic rsp_put(logic [31:0] d, logic s, logic e);
    @(negedge clk); rsp_valid = 1'b1; rsp_data = d; rsp_sop = s; rsp_eop = e;
    @(negedge clk); rsp_valid = 1'b0; rsp_sop = 1'b0; rsp_eop = 1'b0;
  endtask

  task automatic do_reset(int n);
    @(negedge clk); rst = 1'b1;
    repeat (n) @(negedge clk);
    rst = 1'b0;
  endtask

  // {is_read, addr, data-or-expected}
  localparam logic [36:0] VEC [14] = '{
    {1'b1, 4'd7,  32'h0000_0000},
    {1'b1, 4'd2,  32'h0000_0008},
    {1'b1, 4'd8,  32'h0000_0002},
    {1'b1, 4'd6,  32'h0000_0000},
    {1'b0, 4'd7,  32'hFFFF_FFFF},
    {1'b1, 4'd7,  32'h0000_003B},
    {1'b0, 4'd3,  32'h1234_5678},
    {1'b1, 4'd3,  32'h0000_0000},
    {1'b0, 4'd9,  32'hFFFF_FFFF},
    {1'b1, 4'd9,  32'h0000_0000},
    {1'b1, 4'd10, 32'h0000_0000},
    {1'b1, 4'd15, 32'h0000_0000},
    {1'b0, 4'd7,  32'h0000_0000},
    {1'b1, 4'd7,  32'h0000_0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state at the ports
    check("R12 cmd_valid", {31'd0, cmd_valid}, 32'd0);
    check("R12 irq", {31'd0, irq}, 32'd0);
    check("R12 rsp_ready", {31'd0, rsp_ready}, 32'd1);
    @(negedge clk);
    check("R1 idle rvalid", {31'd0, avm_rvalid}, 32'd0);

    // table walk: R12 R8 R6 R9 R11
    for (int i = 0; i < 14; i++) begin
      if (VEC[i][36]) begin
        rd(VEC[i][35:32], v);
        check($sformatf("R9/R11/R12 table row %0d", i), v, VEC[i][31:0]);
      end else begin
        wr(VEC[i][35:32], VEC[i][31:0]);
      end
    end

    // R10 masking of each source
    wr(4'd7, 32'h2);
    check("R10 room irq", {31'd0, irq}, 32'd1);
    wr(4'd7, 32'h1);
    check("R10 masked irq", {31'd0, irq}, 32'd0);
    rsp_put(32'hCAFE_0001, 1'b1, 1'b1);
    check("R10 data irq", {31'd0, irq}, 32'd1);
    rd(4'd8, v);
    check("R8 isr both", v, 32'h3);
    rd(4'd6, v);
    check("R6 single word", v, 32'h7);
    rd(4'd5, v);
    check("R5 pop", v, 32'hCAFE_0001);
    check("R8 self clear irq", {31'd0, irq}, 32'd0);
    rd(4'd5, v);
    check("R7 empty pop", v, 32'd0);
    rd(4'd6, v);
    check("R7 still empty", v, 32'd0);
    wr(4'd7, 32'h0);

    // R6 multiword packet
    for (int i = 0; i < 11; i++) rsp_put(32'hA000_0000 + i, i == 0, i == 10);
    rd(4'd6, v);
    check("R6 eleven words", v, 32'h2D);
    for (int i = 0; i < 10; i++) begin
      rd(4'd5, v);
      check("R5 order", v, 32'hA000_0000 + i);
    end
    rd(4'd6, v);
    check("R6 tail word", v, 32'h6);
    rd(4'd5, v);
    check("R5 last", v, 32'hA000_000A);

    // R5 response full
    for (int i = 0; i < 16; i++) rsp_put(32'hB000_0000 + i, 1'b0, 1'b0);
    check("R5 ready low when full", {31'd0, rsp_ready}, 32'd0);
    rsp_put(32'hDEAD_BEEF, 1'b1, 1'b1);
    for (int i = 0; i < 16; i++) begin
      rd(4'd5, v);
      check("R5 full order", v, 32'hB000_0000 + i);
    end
    rd(4'd5, v);
    check("R5 extra not taken", v, 32'd0);
    check("R5 ready again", {31'd0, rsp_ready}, 32'd1);

    // R2 framing
    wr(4'd0, 32'h1111_0000);
    wr(4'd0, 32'h1111_0001);
    wr(4'd1, 32'h1111_0002);
    wr(4'd1, 32'h2222_0000);
    repeat (4) @(negedge clk);
    rd(4'd2, v);
    check("R4 free after four", v, 32'd4);
    base = cap_n;
    cmd_ready = 1'b1;
    repeat (8) @(negedge clk);
    cmd_ready = 1'b0;
    check("R2 count", 32'(cap_n - base), 32'd4);
    check("R2 word0", 32'(cap[base][33:32]),   32'h2);
    check("R2 word0 data", cap[base][31:0],    32'h1111_0000);
    check("R2 word1", 32'(cap[base+1][33:32]), 32'h0);
    check("R2 word2", 32'(cap[base+2][33:32]), 32'h1);
    check("R2 lone word", 32'(cap[base+3][33:32]), 32'h3);
    check("R2 lone data", cap[base+3][31:0],   32'h2222_0000);

    // R4 lag
    repeat (4) @(negedge clk);
    @(negedge clk); avm_wr = 1'b1; avm_addr = 4'd0; avm_wdata = 32'h3333_0000;
    @(negedge clk); avm_wr = 1'b0;
    @(negedge clk); avm_rd = 1'b1; avm_addr = 4'd2;
    @(negedge clk);
    check("R4 two cycles old", avm_rdata, 32'd8);
    @(negedge clk); avm_rd = 1'b0;
    check("R4 three cycles new", avm_rdata, 32'd7);
    wr(4'd1, 32'h3333_0001);

    // R3 full drop
    for (int i = 0; i < 6; i++) wr(4'd0, 32'h4444_0000 + i);
    wr(4'd1, 32'h5555_5555);
    repeat (4) @(negedge clk);
    rd(4'd2, v);
    check("R3 full free", v, 32'd0);
    rd(4'd8, v);
    check("R8 not-full bit clear", v, 32'd0);
    base = cap_n;
    cmd_ready = 1'b1;
    repeat (12) @(negedge clk);
    cmd_ready = 1'b0;
    check("R3 drained count", 32'(cap_n - base), 32'd8);
    check("R3 last kept", cap[base+7][31:0], 32'h4444_0005);

    // R12 recovery reset
    wr(4'd7, 32'h3);
    do_reset(10);
    rd(4'd7, v);
    check("R12 ier cleared", v, 32'd0);
    repeat (3) @(negedge clk);
    rd(4'd2, v);
    check("R12 free full depth", v, 32'd8);
    check("R12 cmd empty", {31'd0, cmd_valid}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule